// File: doc/BRIEF.md
# CRC Accumulate Execution Unit

This unit executes the CRC accumulate instructions of a 32/64-bit processor. Each request brings a 32-bit instruction word, the running CRC value (taken from the register named by the rt field), the message operand (taken from the register named by the rs field), a feature-enable bit and a 64-bit-mode flag. The unit decodes the word, applies the legality rules, and folds 1, 2, 4 or 8 message bytes into the CRC one byte per cycle. Either the IEEE CRC-32 polynomial or the Castagnoli CRC-32C polynomial is used, both in bit-reflected form.

The request side is valid/ready. `req_ready` is high only while the unit is idle, and a request is taken on a clock edge where both `req_valid` and `req_ready` are high. Operands and configuration bits are sampled only on that edge. The response side is also valid/ready. Once `rsp_valid` rises, every response output holds steady until an edge where `rsp_ready` is high. The unit then returns to idle and raises `req_ready` again. A response carries a sign-extended 32-bit CRC, the destination register index, a write enable and a reserved-instruction flag.

Top module: `crc_exec_unit`

## Requirements
- R1: A word is a CRC instruction only when bits 31:26 equal 0x1F and bits 5:0 equal 0x0F. Any other word gets a response with `rsp_wen`=0, `rsp_ri_exc`=0 and `rsp_value`=0, valid in the cycle right after acceptance.
- R2: Bits 7:6 hold the size code sz. A legal instruction with a nonzero destination consumes 1<<sz bytes (1, 2, 4 or 8). Its response becomes valid exactly 1<<sz clock edges after the accepting edge.
- R3: Bits 10:8 select the polynomial: 0 picks CRC-32 (reflected 0xEDB88320) and 1 picks CRC-32C (reflected 0x82F63B78). Any value of 2 or more raises `rsp_ri_exc`.
- R4: A CRC instruction also raises `rsp_ri_exc` when `cfg_crc_en` is 0, or when sz=3 and `cfg_mode64` is 0. A response with the exception has `rsp_wen`=0 and `rsp_value`=0, and it is valid in the cycle right after acceptance.
- R5: The destination index is bits 20:16 (rt) and is returned on `rsp_dest`. A legal instruction with rt=0 is a no-op. Its response has `rsp_wen`=0 and `rsp_value`=0, and it is valid in the cycle right after acceptance. The exception takes precedence over the no-op.
- R6: The message is cut to its low 8, 16 or 32 bits for sz 0, 1 and 2, and to the full 64 bits for sz 3. Its bytes are consumed least significant first.
- R7: The 32-bit result is sign-extended into bits 63:32 of `rsp_value`.
- R8: The CRC is updated bit-reflected, LSB first, with no inversion of the input CRC or of the result. Only the low 32 bits of `req_crc` are used.
- R9: `req_ready` is low from acceptance until the response is taken. The response outputs stay stable while `rsp_valid` is high and `rsp_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle, able to take a request |
| req_insn | input | 32 | Instruction word |
| req_crc | input | 64 | Running CRC operand (rt register value) |
| req_msg | input | 64 | Message operand (rs register value) |
| cfg_crc_en | input | 1 | CRC feature enabled |
| cfg_mode64 | input | 1 | Core in 64-bit mode |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_value | output | 64 | Sign-extended CRC result |
| rsp_wen | output | 1 | Write `rsp_value` to register `rsp_dest` |
| rsp_dest | output | 5 | Destination register index |
| rsp_ri_exc | output | 1 | Reserved-instruction exception |

## Verification
The bench works out the due time of each response from the decoded fields. Unmatched words, exceptions and no-ops are due at the first falling edge after the accepting rising edge. Legal computations are due 1<<sz rising edges later. After releasing a request, the bench counts falling edges until `rsp_valid` is seen and compares that count with the expected latency. It then compares every response field with a bitwise reference model computed in the bench. It also withholds `rsp_ready` for a random number of cycles and confirms that the outputs have not moved.

// File: rtl/crc_exec_pkg.sv
package crc_exec_pkg;
  localparam logic [31:0] POLY_IEEE_REFL = 32'hEDB88320;
  localparam logic [31:0] POLY_CAST_REFL = 32'h82F63B78;
  localparam logic [5:0]  MAJOR_GROUP    = 6'h1F;
  localparam logic [5:0]  FUNC_CRC       = 6'h0F;

  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_DONE} unit_state_t;

  typedef struct packed {
    logic       hit;
    logic       ri;
    logic       nop;
    logic       cast;
    logic [1:0] sz;
    logic [4:0] dest;
  } crc_dec_t;
endpackage

// File: rtl/crc_decode.sv
module crc_decode
  import crc_exec_pkg::*;
(
  input  logic [31:0] insn,
  input  logic        feat_en,
  input  logic        mode64,
  output crc_dec_t    dec
);
  logic [2:0] pol_sel;
  logic       match;
  logic       illegal;

  always_comb begin
    pol_sel  = insn[10:8];
    match    = (insn[31:26] == MAJOR_GROUP) && (insn[5:0] == FUNC_CRC);
    illegal  = !feat_en || (pol_sel > 3'd1) || ((insn[7:6] == 2'd3) && !mode64);
    dec.hit  = match;
    dec.ri   = match && illegal;
    dec.nop  = match && !illegal && (insn[20:16] == 5'd0);
    dec.cast = pol_sel[0];
    dec.sz   = insn[7:6];
    dec.dest = insn[20:16];
  end
endmodule

// File: rtl/crc_byte_step.sv
module crc_byte_step
  import crc_exec_pkg::*;
#(
  parameter int CRC_W  = 32,
  parameter int BYTE_W = 8
) (
  input  logic [CRC_W-1:0]  crc_in,
  input  logic [BYTE_W-1:0] data_in,
  input  logic              cast,
  output logic [CRC_W-1:0]  crc_out
);
  logic [CRC_W-1:0] poly;
  logic [CRC_W-1:0] stage [BYTE_W+1];

  assign poly     = cast ? POLY_CAST_REFL[CRC_W-1:0] : POLY_IEEE_REFL[CRC_W-1:0];
  assign stage[0] = crc_in;

  for (genvar k = 0; k < BYTE_W; k++) begin : g_bit
    logic fb;
    assign fb         = stage[k][0] ^ data_in[k];
    assign stage[k+1] = (stage[k] >> 1) ^ (fb ? poly : '0);
  end

  assign crc_out = stage[BYTE_W];
endmodule

// File: rtl/crc_exec_unit.sv
module crc_exec_unit
  import crc_exec_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int CRC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [31:0]     req_insn,
  input  logic [XLEN-1:0] req_crc,
  input  logic [XLEN-1:0] req_msg,
  input  logic            cfg_crc_en,
  input  logic            cfg_mode64,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [XLEN-1:0] rsp_value,
  output logic            rsp_wen,
  output logic [4:0]      rsp_dest,
  output logic            rsp_ri_exc
);
  localparam int BYTE_W = 8;
  localparam int NBYTES = XLEN / BYTE_W;
  localparam int CNT_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  unit_state_t      state_q;
  crc_dec_t         dec;
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_nxt;
  logic [XLEN-1:0]  msg_q;
  logic [XLEN-1:0]  msg_cut;
  logic [CNT_W-1:0] cnt_q;
  logic             cast_q;
  logic             wen_q;
  logic             exc_q;
  logic [4:0]       dest_q;
  logic             accept;

  crc_decode u_dec (
    .insn    (req_insn),
    .feat_en (cfg_crc_en),
    .mode64  (cfg_mode64),
    .dec     (dec)
  );

  crc_byte_step #(.CRC_W(CRC_W), .BYTE_W(BYTE_W)) u_step (
    .crc_in  (crc_q),
    .data_in (msg_q[BYTE_W-1:0]),
    .cast    (cast_q),
    .crc_out (crc_nxt)
  );

  for (genvar b = 0; b < NBYTES; b++) begin : g_cut
    assign msg_cut[b*BYTE_W +: BYTE_W] =
      (b < (1 << dec.sz)) ? req_msg[b*BYTE_W +: BYTE_W] : '0;
  end

  assign accept    = req_valid && req_ready;
  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_DONE);
  assign rsp_value = {{(XLEN-CRC_W){crc_q[CRC_W-1]}}, crc_q};
  assign rsp_wen   = wen_q;
  assign rsp_dest  = dest_q;
  assign rsp_ri_exc = exc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      crc_q   <= '0;
      msg_q   <= '0;
      cnt_q   <= '0;
      cast_q  <= 1'b0;
      wen_q   <= 1'b0;
      exc_q   <= 1'b0;
      dest_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          dest_q <= dec.dest;
          cast_q <= dec.cast;
          msg_q  <= msg_cut;
          cnt_q  <= CNT_W'((32'd1 << dec.sz) - 32'd1);
          if (dec.hit && !dec.ri && !dec.nop) begin
            crc_q   <= req_crc[CRC_W-1:0];
            wen_q   <= 1'b1;
            exc_q   <= 1'b0;
            state_q <= ST_BUSY;
          end else begin
            crc_q   <= '0;
            wen_q   <= 1'b0;
            exc_q   <= dec.ri;
            state_q <= ST_DONE;
          end
        end
        ST_BUSY: begin
          crc_q <= crc_nxt;
          msg_q <= msg_q >> BYTE_W;
          if (cnt_q == '0) state_q <= ST_DONE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        ST_DONE: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/crc_exec_unit_chk.sv
module crc_exec_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [31:0]     req_insn,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [XLEN-1:0] rsp_value,
  input logic            rsp_wen,
  input logic [4:0]      rsp_dest,
  input logic            rsp_ri_exc
);
  logic is_crc;
  assign is_crc = (req_insn[31:26] == 6'h1F) && (req_insn[5:0] == 6'h0F);

  p_unmatched_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !is_crc) |=> (rsp_valid && !rsp_wen && !rsp_ri_exc));

  p_badpoly_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && is_crc && (req_insn[10:8] > 3'd1)) |=> (rsp_valid && rsp_ri_exc));

  p_exc_nowrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ri_exc) |-> !rsp_wen);

  p_zero_dest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_dest == 5'd0) |-> !rsp_wen);

  p_sext_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_value[XLEN-1:32] == {(XLEN-32){rsp_value[31]}}));

  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_value) && $stable(rsp_wen)
                                   && $stable(rsp_dest) && $stable(rsp_ri_exc)));
endmodule

bind crc_exec_unit crc_exec_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_insn   (req_insn),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_value  (rsp_value),
  .rsp_wen    (rsp_wen),
  .rsp_dest   (rsp_dest),
  .rsp_ri_exc (rsp_ri_exc)
);

// File: tb/crc_exec_unit_bench.sv
module crc_exec_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_insn = '0;
  logic [63:0] req_crc = '0;
  logic [63:0] req_msg = '0;
  logic        cfg_crc_en = 1'b1;
  logic        cfg_mode64 = 1'b1;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [63:0] rsp_value;
  logic        rsp_wen;
  logic [4:0]  rsp_dest;
  logic        rsp_ri_exc;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  crc_exec_unit u_crc_exec_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_insn(req_insn), .req_crc(req_crc), .req_msg(req_msg),
    .cfg_crc_en(cfg_crc_en), .cfg_mode64(cfg_mode64), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_value(rsp_value), .rsp_wen(rsp_wen),
    .rsp_dest(rsp_dest), .rsp_ri_exc(rsp_ri_exc)
  );

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [63:0] m,
                                          input int nbytes, input bit cast);
    logic [31:0] p;
    logic fb;
    p = cast ? 32'h82F63B78 : 32'hEDB88320;
    for (int i = 0; i < nbytes * 8; i++) begin
      fb = c[0] ^ m[i];
      c = c >> 1;
      if (fb) c = c ^ p;
    end
    return c;
  endfunction

  function automatic logic [31:0] mk_insn(input logic [4:0] rs, input logic [4:0] rt,
                                          input logic [2:0] pol, input logic [1:0] sz);
    return {6'h1F, rs, rt, 5'd0, pol, sz, 6'h0F};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] insn, input logic [63:0] crc, input logic [63:0] msg,
                     input bit en, input bit m64);
    bit hit, exc, wen;
    logic [1:0] sz;
    logic [2:0] pol;
    logic [4:0] rt;
    int nb, lat, n, hold;
    logic [31:0] r;
    logic [63:0] val, snap;
    hit = (insn[31:26] == 6'h1F) && (insn[5:0] == 6'h0F);
    sz = insn[7:6]; pol = insn[10:8]; rt = insn[20:16];
    nb = 1 << sz;
    exc = hit && (!en || pol > 3'd1 || (sz == 2'd3 && !m64));
    wen = hit && !exc && (rt != 5'd0);
    lat = wen ? nb : 0;
    r = ref_crc(crc[31:0], msg, nb, pol[0]);
    val = wen ? {{32{r[31]}}, r} : 64'd0;

    @(negedge clk);
    req_valid = 1'b1; req_insn = insn; req_crc = crc; req_msg = msg;
    cfg_crc_en = en; cfg_mode64 = m64;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_crc = {$urandom, $urandom}; req_msg = {$urandom, $urandom};
    chk(!req_ready, "R9 ready low after accept", 64'(req_ready), 64'd0);
    n = 0;
    while (!rsp_valid && n < 20) begin
      n++;
      @(negedge clk);
    end
    chk(n == lat, "R2 latency", 64'(n), 64'(lat));
    if (!hit) chk(!rsp_wen && !rsp_ri_exc, "R1 unmatched word", {rsp_wen, rsp_ri_exc}, 64'd0);
    chk(rsp_ri_exc == exc, "R3 R4 exception flag", 64'(rsp_ri_exc), 64'(exc));
    chk(rsp_wen == wen, "R5 write enable", 64'(rsp_wen), 64'(wen));
    chk(rsp_value == val, "R6 R7 R8 result", rsp_value, val);
    if (hit) chk(rsp_dest == rt, "R5 destination", 64'(rsp_dest), 64'(rt));
    snap = rsp_value;
    hold = $urandom % 4;
    repeat (hold) @(negedge clk);
    if (hold != 0)
      chk(rsp_valid && rsp_value == snap, "R9 hold under back-pressure", rsp_value, snap);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, "R9 released", {rsp_valid, req_ready}, 64'd1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !finished) begin
        finished = 1'b1;
        mismatched++;
        $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared + 1, mismatched);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h1DC0FFEE));
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid, "R9 reset state", {req_ready, rsp_valid}, 64'd2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R9 idle after reset", {req_ready, rsp_valid}, 64'd2);

    // directed corner cases
    run(mk_insn(5'd2, 5'd3, 3'd0, 2'd0), 64'hFFFFFFFF, 64'h0, 1, 1);              // R8 byte 0 / all-ones crc
    run(mk_insn(5'd2, 5'd3, 3'd1, 2'd0), 64'hFFFFFFFF, 64'h0, 1, 1);              // R3 castagnoli
    run(mk_insn(5'd2, 5'd4, 3'd0, 2'd1), 64'h0, 64'hDEADBEEF_CAFE1234, 1, 1);     // R6 mask halfword
    run(mk_insn(5'd2, 5'd5, 3'd1, 2'd2), 64'hFFFF0000_12345678, 64'hFFFFFFFF_87654321, 1, 1); // R6 R8
    run(mk_insn(5'd2, 5'd6, 3'd0, 2'd3), 64'h89ABCDEF, 64'h01234567_89ABCDEF, 1, 1); // R2 doubleword
    run(mk_insn(5'd2, 5'd6, 3'd0, 2'd3), 64'h89ABCDEF, 64'h01234567_89ABCDEF, 1, 0); // R4 no 64-bit mode
    run(mk_insn(5'd2, 5'd6, 3'd1, 2'd2), 64'h1, 64'h2, 0, 1);                       // R4 feature off
    run(mk_insn(5'd2, 5'd6, 3'd2, 2'd0), 64'h1, 64'h2, 1, 1);                       // R3 bad poly
    run(mk_insn(5'd2, 5'd0, 3'd0, 2'd2), 64'h1, 64'h2, 1, 1);                       // R5 nop
    run(mk_insn(5'd2, 5'd0, 3'd7, 2'd2), 64'h1, 64'h2, 1, 1);                       // R5 exception wins
    run(32'h7C00000E, 64'h1, 64'h2, 1, 1);                                          // R1 wrong function
    run(32'h0000000F, 64'h1, 64'h2, 1, 1);                                          // R1 wrong major

    // constrained random
    for (int i = 0; i < 150; i++) begin
      logic [31:0] w;
      logic [2:0] pol;
      pol = ($urandom % 8 == 0) ? 3'($urandom) : 3'($urandom % 2);
      w = mk_insn(5'($urandom), 5'($urandom), pol, 2'($urandom));
      if ($urandom % 16 == 0) w[5:0] = 6'($urandom);
      run(w, {$urandom, $urandom}, {$urandom, $urandom}, ($urandom % 8) != 0, $urandom % 4 != 0);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule